// File: doc/BRIEF.md
# Data-processing ALU with condition flags

This block is the integer execute unit of a small RISC core. Each cycle it takes two 32-bit operands, a 4-bit opcode, a set-flags bit, the current carry flag and the carry bit produced by the upstream shifter. It returns, one clock later, the result, a destination write strobe and the updated negative, zero, carry and overflow flags. One shared adder serves every arithmetic operation. Each subtraction enters the adder as an addition of the inverted subtrahend, and the carry into the adder is 1 or the incoming carry flag. The carry flag therefore reads as "no borrow" after a subtraction.

Compare and test operations only update flags and never write a destination. A compare or test issued with the set-flags bit low is not a supported operation. It raises a one-cycle illegal indication and leaves all architectural effects out. The shifter, register file, decode and condition evaluation live outside this block.

Top module: `dp_alu`

## Requirements
- R1: While rst_n is low, result, rd_we, illegal_op and all four flags are 0. The reset acts without waiting for a clock edge.
- R2: Every output is registered, so it reflects the inputs present at the previous rising edge. result always holds the value computed from those inputs. rd_we is 1 for every opcode except 1000, 1001, 1010 and 1011, which never write.
- R3: SUB (0010) and CMP (1010) compute op_a + ~op_b + 1. RSB (0011) computes op_b + ~op_a + 1. C is bit 32 of that unsigned sum, so C=1 means no borrow.
- R4: ADD (0100) and CMN (1011) compute op_a + op_b with carry-in 0. ADC (0101) adds carry_in as well. C is the carry out of the full three-term sum.
- R5: SBC (0110) computes op_a + ~op_b + carry_in, and RSC (0111) computes op_b + ~op_a + carry_in. A clear carry_in therefore takes away one extra.
- R6: For arithmetic opcodes, V is 1 when bits 31 and 32 of the sign-extended sum, including the carry-in, differ.
- R7: Flags change only when set_flags is 1. N takes result bit 31, and Z is 1 when the 32-bit result is zero. With set_flags 0, all four flags keep their value.
- R8: An opcode 10xx with set_flags 0 sets illegal_op for exactly that one output cycle. In that cycle rd_we is 0 and the flags keep their value.
- R9: For logical opcodes with set_flags 1, C takes shift_c and V keeps its value.
- R10: The logical results are as follows. AND 0000 and TST 1000 give a&b. EOR 0001 and TEQ 1001 give a^b. ORR 1100 gives a|b. MOV 1101 gives b. BIC 1110 gives a&~b. MVN 1111 gives ~b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, from the shifter |
| shift_c | input | 1 | Carry produced by the shifter |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Update flags when 1 |
| carry_in | input | 1 | Current C flag |
| result | output | 32 | Registered result |
| rd_we | output | 1 | Destination write strobe |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Overflow flag |
| illegal_op | output | 1 | One-cycle illegal operation pulse |

## Verification
The bench aims at add-with-carry where A + B alone does not carry but the carry-in does, as in 0xFFFFFFFF + 0 + 1. A design that took C from A + B would report C=0 and a wrong Z there. Equal-operand subtraction and subtraction with a clear carry-in are also exercised. A borrow-based carry with the wrong polarity would invert C in those cases. Overflow cases depend only on the carry-in, such as 0x7FFFFFFF + 0 + 1. A V computed from operand signs alone would miss them. The bench also checks that logical operations pass the shifter carry and keep V, and that compares issued without set-flags pulse illegal_op for one cycle without disturbing the flags or writing.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         ovf
);
  localparam int UW = W + 1;
  localparam int SW = W + 2;

  logic [UW-1:0] uwide;
  logic [SW-1:0] swide;

  // unsigned widened sum gives the carry out of the top bit
  assign uwide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  // sign-extended sum: overflow when its two top-result bits disagree
  assign swide = {{2{x[W-1]}}, x} + {{2{y[W-1]}}, y} + {{(W+1){1'b0}}, ci};

  assign sum = uwide[W-1:0];
  assign co  = uwide[W];
  assign ovf = swide[W] ^ swide[W-1];
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic import dp_alu_pkg::*; #(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu import dp_alu_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_c,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         rd_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         illegal_op
);
  alu_op_e      op;
  logic [W-1:0] add_x, add_y, add_sum, log_res, res_n;
  logic         add_ci, add_co, add_ovf;
  logic         is_cmp, is_arith, illegal_n, we_n, flag_en;
  nzcv_t        flags_q, flags_n;
  logic [W-1:0] res_q;
  logic         we_q, ill_q;

  assign op = alu_op_e'(opcode);

  // operand steering: subtraction folded into addition of the inverse
  always_comb begin
    add_x  = op_a;
    add_y  = op_b;
    add_ci = 1'b0;
    is_arith = 1'b1;
    case (op)
      OP_SUB, OP_CMP: begin add_y = ~op_b; add_ci = 1'b1; end
      OP_RSB:         begin add_x = op_b; add_y = ~op_a; add_ci = 1'b1; end
      OP_ADD, OP_CMN: add_ci = 1'b0;
      OP_ADC:         add_ci = carry_in;
      OP_SBC:         begin add_y = ~op_b; add_ci = carry_in; end
      OP_RSC:         begin add_x = op_b; add_y = ~op_a; add_ci = carry_in; end
      default:        is_arith = 1'b0;
    endcase
  end

  dp_alu_addsub #(.W(W)) u_add (
    .x(add_x), .y(add_y), .ci(add_ci),
    .sum(add_sum), .co(add_co), .ovf(add_ovf)
  );

  dp_alu_logic #(.W(W)) u_log (
    .op(op), .a(op_a), .b(op_b), .y(log_res)
  );

  assign is_cmp    = (opcode[3:2] == 2'b10);
  assign illegal_n = is_cmp & ~set_flags;
  assign we_n      = ~is_cmp;
  assign flag_en   = set_flags & ~illegal_n;
  assign res_n     = is_arith ? add_sum : log_res;

  always_comb begin
    flags_n.n = res_n[W-1];
    flags_n.z = (res_n == '0);
    flags_n.c = is_arith ? add_co : shift_c;
    flags_n.v = is_arith ? add_ovf : flags_q.v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      we_q    <= 1'b0;
      ill_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      res_q <= res_n;
      we_q  <= we_n;
      ill_q <= illegal_n;
      if (flag_en) flags_q <= flags_n;
    end
  end

  assign result     = res_q;
  assign rd_we      = we_q;
  assign illegal_op = ill_q;
  assign flag_n     = flags_q.n;
  assign flag_z     = flags_q.z;
  assign flag_c     = flags_q.c;
  assign flag_v     = flags_q.v;

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!rd_we && ({flag_n, flag_z, flag_c, flag_v} ==
                    $past({flag_n, flag_z, flag_c, flag_v}))));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!set_flags) |-> ({flag_n, flag_z, flag_c, flag_v} ==
                           $past({flag_n, flag_z, flag_c, flag_v})));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_flags) |-> (flag_z == (result == '0)) && (flag_n == result[W-1]));

  // R9
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_flags && !is_arith) |-> flag_c == $past(shift_c));

  // R9
  logic_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_flags && !is_arith) |-> flag_v == $past(flag_v));

  // R2
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(opcode[3:2] == 2'b10) |-> !rd_we);
endmodule

// File: tb/dp_alu_test.sv
`timescale 1ns/1ps
module dp_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic        shift_c, set_flags, carry_in;
  logic [3:0]  opcode;
  logic [31:0] result;
  logic        rd_we, flag_n, flag_z, flag_c, flag_v, illegal_op;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dp_alu uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .shift_c(shift_c),
    .opcode(opcode), .set_flags(set_flags), .carry_in(carry_in),
    .result(result), .rd_we(rd_we), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .illegal_op(illegal_op)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic        ci;
    logic        shc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  nzcv;
    logic        ill;
  } vec_t;

  localparam int NV = 22;
  // expected flags carry over from the previous vector where they are held
  localparam vec_t VEC [NV] = '{
    '{4'h4,1'b1,1'b0,1'b0,32'h7FFFFFFF,32'h00000001,32'h80000000,1'b1,4'b1001,1'b0}, // R4 R6 ADD overflow
    '{4'h4,1'b1,1'b0,1'b0,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b1,4'b0110,1'b0}, // R4 ADD carry
    '{4'h2,1'b1,1'b0,1'b0,32'h00000005,32'h00000005,32'h00000000,1'b1,4'b0110,1'b0}, // R3 SUB equal
    '{4'h2,1'b1,1'b0,1'b0,32'h00000003,32'h00000005,32'hFFFFFFFE,1'b1,4'b1000,1'b0}, // R3 SUB borrow
    '{4'hA,1'b1,1'b0,1'b0,32'h80000000,32'h00000001,32'h7FFFFFFF,1'b0,4'b0011,1'b0}, // R3 R6 CMP
    '{4'h3,1'b1,1'b0,1'b0,32'h00000001,32'h00000000,32'hFFFFFFFF,1'b1,4'b1000,1'b0}, // R3 RSB
    '{4'h5,1'b1,1'b1,1'b0,32'hFFFFFFFF,32'h00000000,32'h00000000,1'b1,4'b0110,1'b0}, // R4 ADC carry from cin
    '{4'h6,1'b1,1'b0,1'b0,32'h00000005,32'h00000003,32'h00000001,1'b1,4'b0010,1'b0}, // R5 SBC cin 0
    '{4'h7,1'b1,1'b0,1'b0,32'h00000000,32'h00000000,32'hFFFFFFFF,1'b1,4'b1000,1'b0}, // R5 RSC cin 0
    '{4'h5,1'b1,1'b1,1'b0,32'h7FFFFFFF,32'h00000000,32'h80000000,1'b1,4'b1001,1'b0}, // R6 ADC ovf via cin
    '{4'h0,1'b1,1'b0,1'b1,32'h0000F0F0,32'h00000FF0,32'h000000F0,1'b1,4'b0011,1'b0}, // R9 R10 AND
    '{4'hC,1'b0,1'b0,1'b0,32'h00000001,32'h00000002,32'h00000003,1'b1,4'b0011,1'b0}, // R7 R10 ORR no S
    '{4'h8,1'b1,1'b0,1'b0,32'h0000000F,32'h000000F0,32'h00000000,1'b0,4'b0101,1'b0}, // R9 R2 TST
    '{4'hA,1'b0,1'b0,1'b0,32'h00000001,32'h00000001,32'h00000000,1'b0,4'b0101,1'b1}, // R8 CMP no S
    '{4'hF,1'b1,1'b0,1'b1,32'h00000000,32'h00000000,32'hFFFFFFFF,1'b1,4'b1011,1'b0}, // R10 MVN
    '{4'h1,1'b0,1'b0,1'b0,32'h000000FF,32'h0000000F,32'h000000F0,1'b1,4'b1011,1'b0}, // R10 EOR no S
    '{4'hE,1'b1,1'b0,1'b0,32'h000000FF,32'h0000000F,32'h000000F0,1'b1,4'b0001,1'b0}, // R10 BIC
    '{4'hD,1'b1,1'b0,1'b0,32'h00000123,32'h00000000,32'h00000000,1'b1,4'b0101,1'b0}, // R10 MOV
    '{4'h9,1'b1,1'b0,1'b1,32'h00000005,32'h00000005,32'h00000000,1'b0,4'b0111,1'b0}, // R9 TEQ
    '{4'hB,1'b1,1'b0,1'b0,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b0,4'b0110,1'b0}, // R4 CMN
    '{4'h6,1'b1,1'b1,1'b0,32'h00000005,32'h00000005,32'h00000000,1'b1,4'b0110,1'b0}, // R5 SBC cin 1
    '{4'h3,1'b0,1'b0,1'b0,32'h00000002,32'h00000009,32'h00000007,1'b1,4'b0110,1'b0}  // R2 RSB no S
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h2, 4'h3, 4'hA: return "R3";
      4'h4, 4'h5, 4'hB: return "R4";
      4'h6, 4'h7:       return "R5";
      default:          return "R10";
    endcase
  endfunction

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    op_a = v.a; op_b = v.b; opcode = v.op; set_flags = v.s;
    carry_in = v.ci; shift_c = v.shc;
  endtask

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; opcode = 4'h0; set_flags = 1'b0;
    carry_in = 1'b0; shift_c = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check32("R1", "result", result, 32'h0);
    check32("R1", "rd_we/ill", {30'h0, rd_we, illegal_op}, 32'h0);
    check32("R1", "nzcv", {28'h0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check32(tag_of(VEC[i].op), "result", result, VEC[i].res);
      check32("R2", "rd_we", {31'h0, rd_we}, {31'h0, VEC[i].wr});
      check32(VEC[i].s ? "R6" : "R7", "nzcv",
              {28'h0, flag_n, flag_z, flag_c, flag_v}, {28'h0, VEC[i].nzcv});
      check32("R8", "illegal_op", {31'h0, illegal_op}, {31'h0, VEC[i].ill});
    end

    // R8: illegal CMN, then confirm pulse lasts a single cycle
    apply('{4'hB,1'b0,1'b0,1'b0,32'h1,32'h1,32'h2,1'b0,4'b0110,1'b1});
    @(negedge clk);
    check32("R8", "illegal CMN pulse", {31'h0, illegal_op}, 32'h1);
    check32("R8", "illegal CMN flags", {28'h0, flag_n, flag_z, flag_c, flag_v}, 32'h6);
    apply('{4'hD,1'b0,1'b0,1'b0,32'h0,32'h55,32'h55,1'b1,4'b0110,1'b0});
    @(negedge clk);
    check32("R8", "illegal cleared", {31'h0, illegal_op}, 32'h0);
    check32("R10", "MOV result", result, 32'h55);

    // R1: asynchronous reset mid-cycle
    #1 rst_n = 1'b0;
    #0.5;
    check32("R1", "async result", result, 32'h0);
    check32("R1", "async nzcv", {28'h0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
    check32("R1", "async rd_we", {31'h0, rd_we}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule